// File: doc/BRIEF.md
# Delayed-LMS Coefficient Update Engine

This block keeps the coefficients of an N-tap adaptive FIR filter and changes all of them once for every accepted input sample. The step is a delayed least-mean-square correction: each coefficient moves by the scaled error times the input sample that belongs to that tap. The step size is a negative power of two, so scaling the error is an arithmetic right shift. The error comes from a separate error stage, which is not part of this block. The updated coefficients go back to that stage as registered outputs.

The unit keeps its own history of input samples. Each tap reads a copy that is delayed by a fixed alignment distance. This distance matches the latency with which the error arrives, so that each error is paired with the samples that produced it. Each tap multiplier reads the sample as two-bit digits and builds its partial products from a small set of error multiples (one, two and three times the scaled error, plus the negatives needed for the signed top digit). These multiples are formed once and shared by all taps. A shift-add chain adds the partial products, the sum is added to the old coefficient, and the result saturates instead of wrapping.

Top module: `dlmsWeightUpdate`

## Requirements
- R1: While reset is low, every coefficient is zero. At the first clock edge after reset is released, every coefficient still reads zero.
- R2: At a clock edge where `sampleValid` is low, no coefficient changes and the sample history does not shift, whatever `errIn` and `sampleIn` are doing.
- R3: The scaled error is `errIn` (two's complement) arithmetically shifted right by `MU_SHIFT`, which rounds toward minus infinity. With `MU_SHIFT`=2: an error of -1 scales to -1, an error of 3 scales to 0, and an error of -5 scales to -2.
- R4: At a clock edge where `sampleValid` is high, tap i becomes sat(w_i + s·x_i), where s is the scaled error and x_i is the tap's aligned sample read as a signed XW-bit value. The product is exact over the whole sample range, including the most negative sample.
- R5: Tap i uses the sample that was presented with the strobe ALIGN_DLY+i strobes before the current one. Strobe 0 is the current `sampleIn`. Before that many strobes have been seen since reset, the sample is taken as zero.
- R6: A sum above 2^(WW-1)-1 is clamped to 2^(WW-1)-1, and a sum below -2^(WW-1) is clamped to -2^(WW-1). A coefficient never wraps.
- R7: A strobe at one clock edge changes the coefficients at that edge, and the new values are on `weightsOut` right after it. Before that edge the outputs still show the old values.
- R8: Tap i occupies bits [i·WW +: WW] of `weightsOut`, in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe: accept a sample and apply one update |
| sampleIn | input | XW | Newest input sample, two's complement |
| errIn | input | EW | Error aligned with the sample history, two's complement |
| weightsOut | output | NTAPS·WW | Registered coefficients, tap i at bits [i·WW +: WW] |

## Verification
A wrong internal value shows at the ports on the very next strobe. A wrong decoded digit, a bad shared multiple, or a mis-signed top digit produces a coefficient step that is off by a multiple of the scaled error. A history that shifts at the wrong time moves a sample to the wrong tap, and this becomes visible in the weights one strobe later. The bench sweeps every sample value against error values that include both extremes and the small values near the rounding point. Frequent resets keep the coefficients inside the range where each step can be seen. Separate runs drive the coefficients into both saturation limits.

// File: rtl/dlmsWuPkg.sv
package dlmsWuPkg;

  // Strobes the control issues to the datapath for one clock cycle.
  typedef struct packed {
    logic shiftLine;    // advance the sample history
    logic loadWeights;  // commit the updated coefficients
  } wuStrobes_t;

  // Larger of two widths, used for sizing the accumulation adder.
  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dlmsWuCtrl.sv
module dlmsWuCtrl
  import dlmsWuPkg::*;
(
  input  logic       rstN,
  input  logic       sampleValid,
  output wuStrobes_t strobes
);

  // One accepted sample both advances the history and commits the
  // update; both are held off while reset is asserted.
  always_comb begin
    strobes.shiftLine   = sampleValid & rstN;
    strobes.loadWeights = sampleValid & rstN;
  end

endmodule

// File: rtl/dlmsWuScale.sv
module dlmsWuScale #(
  parameter int EW       = 10,
  parameter int MU_SHIFT = 2,
  localparam int SEW     = EW + 2
) (
  input  logic [EW-1:0]         errIn,
  output logic signed [SEW-1:0] mulOne,
  output logic signed [SEW-1:0] mulTwo,
  output logic signed [SEW-1:0] mulThree,
  output logic signed [SEW-1:0] negOne,
  output logic signed [SEW-1:0] negTwo
);

  logic signed [EW-1:0]  scaled;
  logic signed [SEW-1:0] scaledExt;

  // Step size is 2^-MU_SHIFT: arithmetic shift, rounding toward -inf.
  assign scaled    = $signed(errIn) >>> MU_SHIFT;
  assign scaledExt = {{(SEW-EW){scaled[EW-1]}}, scaled};

  // Multiples shared by every tap multiplier.
  assign mulOne   = scaledExt;
  assign mulTwo   = scaledExt <<< 1;
  assign mulThree = mulTwo + scaledExt;
  assign negOne   = -scaledExt;
  assign negTwo   = -mulTwo;

endmodule

// File: rtl/dlmsWuTapMac.sv
module dlmsWuTapMac
  import dlmsWuPkg::*;
#(
  parameter int XW  = 8,
  parameter int SEW = 12,
  parameter int WW  = 16,
  localparam int ND = XW / 2,
  localparam int PW = SEW + XW,
  localparam int AW = maxOf(WW, PW) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [XW-1:0]         xTap,
  input  logic signed [SEW-1:0] mulOne,
  input  logic signed [SEW-1:0] mulTwo,
  input  logic signed [SEW-1:0] mulThree,
  input  logic signed [SEW-1:0] negOne,
  input  logic signed [SEW-1:0] negTwo,
  output logic [WW-1:0]         weight
);

  localparam logic signed [AW-1:0] SAT_HI = {{(AW-WW+1){1'b0}}, {(WW-1){1'b1}}};
  localparam logic signed [AW-1:0] SAT_LO = {{(AW-WW+1){1'b1}}, {(WW-1){1'b0}}};

  logic signed [SEW-1:0] partial [ND];
  logic signed [PW-1:0]  partialExt [ND];

  // One partial product per two-bit digit: decode, then AND-OR select.
  for (genvar k = 0; k < ND; k++) begin : g_digit
    logic [1:0] dig;
    logic       selA;
    logic       selB;
    logic       selC;
    assign dig  = xTap[2*k +: 2];
    assign selA = dig[0] & ~dig[1];
    assign selB = ~dig[0] & dig[1];
    assign selC = dig[0] & dig[1];
    if (k == ND - 1) begin : g_top
      // Signed top digit: 01 -> +1, 10 -> -2, 11 -> -1.
      assign partial[k] = ({SEW{selA}} & mulOne)
                        | ({SEW{selB}} & negTwo)
                        | ({SEW{selC}} & negOne);
    end else begin : g_low
      assign partial[k] = ({SEW{selA}} & mulOne)
                        | ({SEW{selB}} & mulTwo)
                        | ({SEW{selC}} & mulThree);
    end
    assign partialExt[k] = {{(PW-SEW){partial[k][SEW-1]}}, partial[k]};
  end

  // Shift-add chain combining the digit products by place value.
  logic signed [PW-1:0] product;
  always_comb begin
    product = '0;
    for (int k = 0; k < ND; k++) begin
      product = product + (partialExt[k] <<< (2 * k));
    end
  end

  logic signed [AW-1:0] sumWide;
  logic signed [AW-1:0] sumSat;
  assign sumWide = {{(AW-WW){weight[WW-1]}}, weight}
                 + {{(AW-PW){product[PW-1]}}, product};

  always_comb begin
    if (sumWide > SAT_HI) begin
      sumSat = SAT_HI;
    end else if (sumWide < SAT_LO) begin
      sumSat = SAT_LO;
    end else begin
      sumSat = sumWide;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weight <= '0;
    end else if (load) begin
      weight <= sumSat[WW-1:0];
    end
  end

endmodule

// File: rtl/dlmsWuDatapath.sv
module dlmsWuDatapath
  import dlmsWuPkg::*;
#(
  parameter int NTAPS     = 4,
  parameter int XW        = 8,
  parameter int EW        = 10,
  parameter int WW        = 16,
  parameter int MU_SHIFT  = 2,
  parameter int ALIGN_DLY = 1,
  localparam int SEW      = EW + 2,
  localparam int LINE     = NTAPS + ALIGN_DLY - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wuStrobes_t            strobes,
  input  logic [XW-1:0]         sampleIn,
  input  logic [EW-1:0]         errIn,
  output logic [NTAPS*WW-1:0]   weightsOut
);

  // Sample history: histView[0] is the sample arriving now.
  logic [XW-1:0] lineReg  [LINE];
  logic [XW-1:0] histView [LINE+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < LINE; j++) begin
        lineReg[j] <= '0;
      end
    end else if (strobes.shiftLine) begin
      lineReg[0] <= sampleIn;
      for (int j = 1; j < LINE; j++) begin
        lineReg[j] <= lineReg[j-1];
      end
    end
  end

  always_comb begin
    histView[0] = sampleIn;
    for (int j = 1; j <= LINE; j++) begin
      histView[j] = lineReg[j-1];
    end
  end

  logic signed [SEW-1:0] mulOne;
  logic signed [SEW-1:0] mulTwo;
  logic signed [SEW-1:0] mulThree;
  logic signed [SEW-1:0] negOne;
  logic signed [SEW-1:0] negTwo;

  dlmsWuScale #(
    .EW       (EW),
    .MU_SHIFT (MU_SHIFT)
  ) scale_i (
    .errIn    (errIn),
    .mulOne   (mulOne),
    .mulTwo   (mulTwo),
    .mulThree (mulThree),
    .negOne   (negOne),
    .negTwo   (negTwo)
  );

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    dlmsWuTapMac #(
      .XW  (XW),
      .SEW (SEW),
      .WW  (WW)
    ) mac_i (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobes.loadWeights),
      .xTap     (histView[ALIGN_DLY+i]),
      .mulOne   (mulOne),
      .mulTwo   (mulTwo),
      .mulThree (mulThree),
      .negOne   (negOne),
      .negTwo   (negTwo),
      .weight   (weightsOut[i*WW +: WW])
    );
  end

endmodule

// File: rtl/dlmsWeightUpdate.sv
module dlmsWeightUpdate
  import dlmsWuPkg::*;
#(
  parameter int NTAPS     = 4,
  parameter int XW        = 8,
  parameter int EW        = 10,
  parameter int WW        = 16,
  parameter int MU_SHIFT  = 2,
  parameter int ALIGN_DLY = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [XW-1:0]       sampleIn,
  input  logic [EW-1:0]       errIn,
  output logic [NTAPS*WW-1:0] weightsOut
);

  wuStrobes_t strobes;

  dlmsWuCtrl ctrl_i (
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .strobes     (strobes)
  );

  dlmsWuDatapath #(
    .NTAPS     (NTAPS),
    .XW        (XW),
    .EW        (EW),
    .WW        (WW),
    .MU_SHIFT  (MU_SHIFT),
    .ALIGN_DLY (ALIGN_DLY)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sampleIn   (sampleIn),
    .errIn      (errIn),
    .weightsOut (weightsOut)
  );

endmodule

// File: rtl/dlmsWeightUpdate_chk.sv
module dlmsWeightUpdate_chk #(
  parameter int NTAPS    = 4,
  parameter int XW       = 8,
  parameter int EW       = 10,
  parameter int WW       = 16,
  parameter int MU_SHIFT = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [EW-1:0]       errIn,
  input logic [NTAPS*WW-1:0] weightsOut
);

  // Largest possible single-step change: most negative error times most
  // negative sample, both after scaling.
  localparam longint STEP_MAX =
    (longint'(1) <<< (EW - 1 - MU_SHIFT)) * (longint'(1) <<< (XW - 1));

  logic [NTAPS*WW-1:0] prevWeights;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWeights <= '0;
    end else begin
      prevWeights <= weightsOut;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (weightsOut == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(weightsOut));

  // R3
  small_err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ((errIn >> MU_SHIFT) == '0)) |=> $stable(weightsOut));

  for (genvar i = 0; i < NTAPS; i++) begin : g_step
    longint delta;
    always_comb begin
      delta = longint'($signed(weightsOut[i*WW +: WW]))
            - longint'($signed(prevWeights[i*WW +: WW]));
    end
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (delta <= STEP_MAX) && (delta >= -STEP_MAX));
  end

endmodule

bind dlmsWeightUpdate dlmsWeightUpdate_chk #(
  .NTAPS    (NTAPS),
  .XW       (XW),
  .EW       (EW),
  .WW       (WW),
  .MU_SHIFT (MU_SHIFT)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .errIn       (errIn),
  .weightsOut  (weightsOut)
);

// File: tb/dlmsWeightUpdate_tb.sv
`timescale 1ns/1ps
module dlmsWeightUpdate_tb_top;

  localparam int NT   = 4;
  localparam int XW   = 8;
  localparam int EW   = 10;
  localparam int WW   = 16;
  localparam int MU   = 2;
  localparam int D    = 1;
  localparam int LINE = NT + D - 1;
  localparam int WMAX = (1 <<< (WW - 1)) - 1;
  localparam int WMIN = -(1 <<< (WW - 1));

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic [XW-1:0]      sampleIn = '0;
  logic [EW-1:0]      errIn = '0;
  logic [NT*WW-1:0]   weightsOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int mW [NT];
  int mLine [LINE];

  always #2.5 clk = ~clk;

  dlmsWeightUpdate #(
    .NTAPS(NT), .XW(XW), .EW(EW), .WW(WW), .MU_SHIFT(MU), .ALIGN_DLY(D)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .errIn(errIn), .weightsOut(weightsOut)
  );

  function automatic int tapOut(input int i);
    logic signed [WW-1:0] v;
    v = weightsOut[i*WW +: WW];
    return int'(v);
  endfunction

  task automatic check(input string req, input int tap, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tap %0d: actual %0d expected %0d", req, tap, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < NT; i++) check(req, i, tapOut(i), mW[i]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NT; i++) mW[i] = 0;
    for (int j = 0; j < LINE; j++) mLine[j] = 0;
    // R1: zero after reset and after the first edge out of reset
    checkAll("R1");
    @(negedge clk);
    checkAll("R1");
  endtask

  // One strobe: inputs driven at a falling edge, committed at the next
  // rising edge, checked at the following falling edge.
  task automatic strobe(input int x, input int e, input string req);
    int cur [LINE+1];
    int se;
    longint s;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = x[XW-1:0];
    errIn = e[EW-1:0];
    #1;
    // R7: outputs unchanged before the committing edge
    checkAll("R7");
    @(negedge clk);
    sampleValid = 1'b0;
    cur[0] = x;
    for (int j = 0; j < LINE; j++) cur[j+1] = mLine[j];
    se = e >>> MU;
    for (int i = 0; i < NT; i++) begin
      s = longint'(mW[i]) + longint'(se) * longint'(cur[D+i]);
      if (s > WMAX) s = WMAX;
      if (s < WMIN) s = WMIN;
      mW[i] = int'(s);
    end
    for (int j = LINE - 1; j > 0; j--) mLine[j] = mLine[j-1];
    mLine[0] = x;
    checkAll(req);
  endtask

  initial begin
    int errSet [7];
    int n;
    errSet = '{-512, -5, -1, 3, 4, 511, -200};
    doReset();

    // R5: impulse walks through the taps with alignment D
    strobe(1, 4, "R5");
    for (int k = 0; k < NT + 1; k++) strobe(0, 4, "R5");

    // R3: rounding of the scaled error toward minus infinity
    doReset();
    strobe(1, 0, "R3");
    strobe(0, -1, "R3");
    strobe(0, 3, "R3");
    strobe(0, -5, "R3");

    // R2: idle cycles with moving inputs change nothing
    doReset();
    strobe(7, 100, "R2");
    strobe(-9, 100, "R2");
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      sampleIn = XW'(c * 37);
      errIn = EW'(c * 91 + 5);
      checkAll("R2");
    end
    strobe(0, 64, "R2");
    strobe(0, 64, "R2");

    // R4, R8: sweep every sample value against a set of error values
    n = 0;
    for (int x = -(1 <<< (XW - 1)); x < (1 <<< (XW - 1)); x++) begin
      for (int q = 0; q < 7; q++) begin
        if (n % 3 == 0) doReset();
        strobe(x, errSet[q], "R4");
        n++;
      end
    end

    // R6: drive into the positive limit, then the negative one
    doReset();
    for (int k = 0; k < 12; k++) strobe(127, 511, "R6");
    for (int i = 0; i < NT; i++) check("R6", i, tapOut(i), WMAX);
    for (int k = 0; k < 30; k++) strobe(-128, 511, "R6");
    for (int i = 0; i < NT; i++) check("R6", i, tapOut(i), WMIN);
    for (int k = 0; k < 6; k++) strobe(-128, -512, "R6");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule